// File: doc/BRIEF.md
# Fractional-N Frequency Step Controller

This block lets a fractional-N synthesizer be nudged up or down in frequency at run time. It holds the integer divider value and the fractional numerator that feed a sigma-delta modulator. On each trigger it adds a programmable step to that numerator or subtracts it, and the integer value absorbs any carry or borrow against a fixed denominator. Every change is announced to the modulator with a one-cycle update strobe.

Trigger pulses come from one of two sources. One is a pair of asynchronous pins, driven for example by an external controller. The other is a pair of trigger bits written by software. A source-select input chooses which pair is live. A global enable gates all stepping. When the enable rises, and in the first cycle after reset, the block reloads the divider value and numerator from their programmed base values.

Top module: `freq_step_top`

## Requirements
- R1: In the first cycle after reset, and on every 0-to-1 transition of `stepEn`, `nOut` and `numOut` are loaded from `baseN` and `baseNum`, and `updStb` is high in the following cycle.
- R2: An applied increment with `numOut + stepDelta < denom` sets `numOut` to `numOut + stepDelta` and leaves `nOut` unchanged. `stepDelta` is required to be below `denom`.
- R3: An applied increment with `numOut + stepDelta >= denom` sets `numOut` to `numOut + stepDelta - denom` and raises `nOut` by one.
- R4: An applied decrement with `numOut >= stepDelta` sets `numOut` to `numOut - stepDelta` and leaves `nOut` unchanged.
- R5: An applied decrement with `numOut < stepDelta` sets `numOut` to `numOut + denom - stepDelta` and lowers `nOut` by one. `nOut` wraps modulo 2^N_W.
- R6: While `stepEn` is 0, trigger edges from either source leave `nOut` and `numOut` unchanged and raise no strobe.
- R7: `srcSel` = 0 takes triggers from the pins and `srcSel` = 1 takes them from `regTrig`. Edges on the unselected source have no effect.
- R8: In `regTrig`, bit 0 is the increment trigger and bit 1 is the decrement trigger. Only a 0-to-1 transition steps, so holding a bit high gives exactly one step.
- R9: A pin rising edge passes through a two-stage synchronizer and an edge detector. If the pin rises before clock edge k, the outputs are unchanged after edges k and k+1 and have stepped after edge k+2.
- R10: An increment edge and a decrement edge in the same cycle cancel. The state is unchanged and no strobe is raised.
- R11: `updStb` is high for exactly one cycle after each load or applied step, and low otherwise.
- R12: A load and a step edge in the same cycle result in the load values only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepEn | input | 1 | Global stepping enable; its rising edge reloads the base values |
| srcSel | input | 1 | Trigger source: 0 = pins, 1 = register bits |
| regTrig | input | 2 | Register triggers: bit 0 increment, bit 1 decrement |
| gpioInc | input | 1 | Asynchronous increment trigger pin |
| gpioDec | input | 1 | Asynchronous decrement trigger pin |
| stepDelta | input | DELTA_W (16) | Numerator step size |
| denom | input | NUM_W (24) | Fixed fractional denominator |
| baseN | input | N_W (8) | Base integer divider value |
| baseNum | input | NUM_W (24) | Base fractional numerator |
| nOut | output | N_W (8) | Current integer divider value |
| numOut | output | NUM_W (24) | Current fractional numerator |
| updStb | output | 1 | One-cycle update strobe to the modulator |

## Verification
Two pairs of events can meet in one cycle. The first is an increment edge with a decrement edge. The bench provokes it by writing both register trigger bits from 00 to 11 at once, and by raising both pins on the same clock edge. It judges the result as unchanged outputs and no strobe for several cycles afterwards. The second is a reload with a step. The bench raises `stepEn` in the same cycle as a register increment edge and expects exactly the base values with a single strobe.

// File: rtl/freq_step_pkg.sv
package freq_step_pkg;

  // Strobes from the control section to the datapath, valid for one cycle.
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } stepCmd_t;

  // Index of each trigger inside the two-bit trigger vectors.
  localparam int TRIG_INC = 0;
  localparam int TRIG_DEC = 1;

endpackage

// File: rtl/freq_step_ctrl.sv
module freq_step_ctrl
  import freq_step_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepEn,
  input  logic       srcSel,
  input  logic [1:0] regTrig,
  input  logic       gpioInc,
  input  logic       gpioDec,
  output stepCmd_t   cmd
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [1:0] pins;
  logic [1:0] pinEdge;
  logic [1:0] regPrev;
  logic [1:0] regEdge;
  logic [1:0] selEdge;
  logic       enPrev;
  logic       loadPend;

  assign pins[TRIG_INC] = gpioInc;
  assign pins[TRIG_DEC] = gpioDec;

  // One synchronizer and edge detector per trigger pin.
  for (genvar i = 0; i < 2; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], pins[i]};
        prevQ <= syncQ[LAST];
      end
    end

    assign pinEdge[i] = syncQ[LAST] & ~prevQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPrev  <= '0;
      enPrev   <= 1'b0;
      loadPend <= 1'b1;
    end else begin
      regPrev  <= regTrig;
      enPrev   <= stepEn;
      loadPend <= 1'b0;
    end
  end

  assign regEdge = regTrig & ~regPrev;
  assign selEdge = srcSel ? regEdge : pinEdge;

  always_comb begin
    cmd.load = loadPend | (stepEn & ~enPrev);
    cmd.inc  = stepEn & selEdge[TRIG_INC];
    cmd.dec  = stepEn & selEdge[TRIG_DEC];
  end

  // R8: a register increment bit already high in the previous cycle gives no new step.
  p_hold_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && srcSel && $past(srcSel) && regTrig[TRIG_INC] && $past(regTrig[TRIG_INC]))
      |-> !cmd.inc);

  // R1: a rise of the enable always requests a load.
  p_en_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stepEn) |-> cmd.load);

endmodule

// File: rtl/freq_step_dp.sv
module freq_step_dp
  import freq_step_pkg::*;
#(
  parameter int N_W     = 8,
  parameter int NUM_W   = 24,
  parameter int DELTA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  stepCmd_t           cmd,
  input  logic [DELTA_W-1:0] stepDelta,
  input  logic [NUM_W-1:0]   denom,
  input  logic [N_W-1:0]     baseN,
  input  logic [NUM_W-1:0]   baseNum,
  output logic [N_W-1:0]     nOut,
  output logic [NUM_W-1:0]   numOut,
  output logic               updStb
);

  localparam int PAD_W = NUM_W - DELTA_W;

  logic [N_W-1:0]   nQ;
  logic [NUM_W-1:0] numQ;
  logic             updQ;
  logic [NUM_W-1:0] deltaExt;
  logic [NUM_W:0]   sumInc;
  logic             incCarry;
  logic             decBorrow;
  logic             oneStep;

  assign deltaExt  = {{PAD_W{1'b0}}, stepDelta};
  assign sumInc    = {1'b0, numQ} + {1'b0, deltaExt};
  assign incCarry  = sumInc >= {1'b0, denom};
  assign decBorrow = numQ < deltaExt;
  assign oneStep   = cmd.inc ^ cmd.dec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nQ   <= '0;
      numQ <= '0;
      updQ <= 1'b0;
    end else if (cmd.load) begin
      nQ   <= baseN;
      numQ <= baseNum;
      updQ <= 1'b1;
    end else if (oneStep) begin
      updQ <= 1'b1;
      if (cmd.inc) begin
        if (incCarry) begin
          numQ <= NUM_W'(sumInc - {1'b0, denom});
          nQ   <= nQ + 1'b1;
        end else begin
          numQ <= sumInc[NUM_W-1:0];
        end
      end else begin
        if (decBorrow) begin
          numQ <= numQ + denom - deltaExt;
          nQ   <= nQ - 1'b1;
        end else begin
          numQ <= numQ - deltaExt;
        end
      end
    end else begin
      updQ <= 1'b0;
    end
  end

  assign nOut   = nQ;
  assign numOut = numQ;
  assign updStb = updQ;

  // R2: a single step keeps an in-range numerator in range.
  p_num_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && oneStep && numQ < denom && deltaExt < denom) |=> numQ < $past(denom));

  // R3: an increment carry raises the integer value by one.
  p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && cmd.inc && !cmd.dec && incCarry) |=> nQ == N_W'($past(nQ) + 1'b1));

  // R5: a decrement borrow lowers the integer value by one.
  p_dec_borrow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && cmd.dec && !cmd.inc && decBorrow) |=> nQ == N_W'($past(nQ) - 1'b1));

  // R10: simultaneous edges cancel.
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && cmd.inc && cmd.dec) |=> ($stable(nQ) && $stable(numQ) && !updQ));

  // R11: no strobe without a load or an applied step.
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !oneStep) |=> !updQ);

endmodule

// File: rtl/freq_step_top.sv
module freq_step_top
  import freq_step_pkg::*;
#(
  parameter int N_W         = 8,
  parameter int NUM_W       = 24,
  parameter int DELTA_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepEn,
  input  logic               srcSel,
  input  logic [1:0]         regTrig,
  input  logic               gpioInc,
  input  logic               gpioDec,
  input  logic [DELTA_W-1:0] stepDelta,
  input  logic [NUM_W-1:0]   denom,
  input  logic [N_W-1:0]     baseN,
  input  logic [NUM_W-1:0]   baseNum,
  output logic [N_W-1:0]     nOut,
  output logic [NUM_W-1:0]   numOut,
  output logic               updStb
);

  stepCmd_t cmd;

  freq_step_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .stepEn  (stepEn),
    .srcSel  (srcSel),
    .regTrig (regTrig),
    .gpioInc (gpioInc),
    .gpioDec (gpioDec),
    .cmd     (cmd)
  );

  freq_step_dp #(.N_W(N_W), .NUM_W(NUM_W), .DELTA_W(DELTA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .stepDelta (stepDelta),
    .denom     (denom),
    .baseN     (baseN),
    .baseNum   (baseNum),
    .nOut      (nOut),
    .numOut    (numOut),
    .updStb    (updStb)
  );

  // R6: with the enable low and no pending load, the state holds and no strobe follows.
  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !cmd.load) |=> ($stable(nOut) && $stable(numOut) && !updStb));

endmodule

// File: tb/freq_step_top_tb_top.sv
module freq_step_top_tb_top;

  localparam int NW = 8;
  localparam int MODN = 1 << NW;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic        srcSel = 1'b1;
  logic [1:0]  regTrig = 2'b00;
  logic        gpioInc = 1'b0;
  logic        gpioDec = 1'b0;
  logic [15:0] stepDelta = 16'd1;
  logic [23:0] denom = 24'd7;
  logic [7:0]  baseN = 8'd5;
  logic [23:0] baseNum = 24'd3;
  logic [7:0]  nOut;
  logic [23:0] numOut;
  logic        updStb;

  int checks = 0;
  int fails = 0;
  int den = 7;
  int total = 0;
  int delta = 1;

  always #2 clk = ~clk;

  freq_step_top dut_i (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .srcSel(srcSel), .regTrig(regTrig),
    .gpioInc(gpioInc), .gpioDec(gpioDec), .stepDelta(stepDelta), .denom(denom),
    .baseN(baseN), .baseNum(baseNum), .nOut(nOut), .numOut(numOut), .updStb(updStb)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkState(string req);
    chk(req, int'(nOut), total / den);
    chk(req, int'(numOut), total % den);
  endtask

  task automatic quiet(string req, int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req, int'(updStb), 0);
    end
    chkState(req);
  endtask

  function automatic string stepModel(bit up);
    string tag;
    int m = MODN * den;
    if (up) begin
      tag = ((total % den) + delta >= den) ? "R3" : "R2";
      total = (total + delta) % m;
    end else begin
      tag = ((total % den) < delta) ? "R5" : "R4";
      total = (total - delta + m) % m;
    end
    return tag;
  endfunction

  task automatic regStep(bit up);
    string tag;
    tag = stepModel(up);
    @(negedge clk) regTrig = up ? 2'b01 : 2'b10;
    @(negedge clk);
    chk("R11", int'(updStb), 1);
    chkState(tag);
    regTrig = 2'b00;
    @(negedge clk);
    chk("R11", int'(updStb), 0);
  endtask

  task automatic gpioStep(bit up);
    int oldTotal = total;
    string tag;
    tag = stepModel(up);
    @(negedge clk);
    if (up) gpioInc = 1'b1; else gpioDec = 1'b1;
    @(negedge clk);
    chk("R9", int'(nOut), oldTotal / den);
    chk("R9", int'(numOut), oldTotal % den);
    @(negedge clk);
    chk("R9", int'(numOut), oldTotal % den);
    chk("R9", int'(updStb), 0);
    @(negedge clk);
    chkState(tag);
    chk("R9", int'(updStb), 1);
    gpioInc = 1'b0;
    gpioDec = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic reload(int nb, int nm, int d);
    @(negedge clk) stepEn = 1'b0;
    denom = 24'(d);
    baseN = 8'(nb);
    baseNum = 24'(nm);
    den = d;
    @(negedge clk) stepEn = 1'b1;
    total = nb * d + nm;
    @(negedge clk);
    chk("R1", int'(updStb), 1);
    chkState("R1");
    @(negedge clk);
    chk("R11", int'(updStb), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int dens[3] = '{5, 7, 13};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    total = 5 * 7 + 3;
    @(negedge clk);
    // R1: first cycle after reset loads the base values
    chk("R1", int'(updStb), 1);
    chkState("R1");
    @(negedge clk);
    chk("R11", int'(updStb), 0);

    // Sweep denominators and every legal step size, register triggers
    foreach (dens[k]) begin
      reload(1, dens[k] - 2, dens[k]);
      for (int d = 1; d < dens[k]; d++) begin
        @(negedge clk) stepDelta = 16'(d);
        delta = d;
        for (int s = 0; s < 5; s++) regStep(1'b1);
        for (int s = 0; s < 9; s++) regStep(1'b0);
      end
    end

    // R8: holding an increment bit steps only once
    delta = 4;
    @(negedge clk) stepDelta = 16'd4;
    void'(stepModel(1'b1));
    @(negedge clk) regTrig = 2'b01;
    @(negedge clk);
    chkState("R8");
    quiet("R8", 5);
    @(negedge clk) regTrig = 2'b00;
    quiet("R8", 2);

    // R10: both register bits rise together
    @(negedge clk) regTrig = 2'b11;
    quiet("R10", 5);
    @(negedge clk) regTrig = 2'b00;
    quiet("R10", 2);

    // R6: disabled, register edges ignored
    @(negedge clk) stepEn = 1'b0;
    quiet("R6", 2);
    @(negedge clk) regTrig = 2'b01;
    quiet("R6", 3);
    @(negedge clk) regTrig = 2'b00;
    @(negedge clk) regTrig = 2'b10;
    quiet("R6", 3);
    @(negedge clk) regTrig = 2'b00;
    quiet("R6", 2);
    reload(3, 2, 13);

    // R7: register source selected, pin edges ignored
    @(negedge clk) gpioInc = 1'b1;
    quiet("R7", 6);
    @(negedge clk) gpioInc = 1'b0;
    quiet("R7", 4);

    // Switch to pins: register edges ignored, pin steps with sync latency
    @(negedge clk) srcSel = 1'b0;
    @(negedge clk) regTrig = 2'b01;
    quiet("R7", 3);
    @(negedge clk) regTrig = 2'b00;
    quiet("R7", 2);
    for (int s = 0; s < 4; s++) gpioStep(1'b1);
    for (int s = 0; s < 6; s++) gpioStep(1'b0);

    // R10: both pins rise on the same edge
    @(negedge clk);
    gpioInc = 1'b1;
    gpioDec = 1'b1;
    quiet("R10", 6);
    @(negedge clk);
    gpioInc = 1'b0;
    gpioDec = 1'b0;
    quiet("R10", 4);

    // R12: enable rise and increment edge in the same cycle
    @(negedge clk);
    srcSel = 1'b1;
    stepEn = 1'b0;
    baseN = 8'd9;
    baseNum = 24'd0;
    @(negedge clk);
    stepEn = 1'b1;
    regTrig = 2'b01;
    total = 9 * den;
    @(negedge clk);
    chkState("R12");
    chk("R12", int'(updStb), 1);
    regTrig = 2'b00;
    quiet("R12", 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule